// File: doc/BRIEF.md
# Time-Shared Multi-Channel Event Counter

This block keeps an event count for each of 64 channels. The counts do not live in 64 separate counter registers. They sit in one on-chip RAM of 256 words by 16 bits. A control sequencer walks a channel index through every channel in ascending order. Each channel gets a two-cycle slot: the first cycle reads the stored count and samples that channel's event flag, and the second cycle writes the count back, one higher if the flag was set. The sensor front end (synchronisation and edge detection) is outside the block. It supplies a single `eventFlag` bit for whichever channel `scanCh` currently names, and that bit is sampled while `scanSample` is high.

Each sweep over all channels is followed by a host window of `HOST_WIN` cycles, announced by a one-cycle `scanDone` pulse. During the window a host controller uses the RAM's second port to read counts, clear them or preload test values by channel address. Host accesses are accepted at any time. If the host writes a channel while that channel is in its read or write-back slot, the host value is kept and the scan result is dropped. A parameter chooses whether a count at its maximum wraps to zero or holds.

Top module: `event_tally`

## Requirements
- R1: While `rst` is high, and for exactly one cycle after it falls, `scanSample`, `scanDone` and `hostWindow` are low and `scanCh` is 0. In that cycle `eventFlag` is ignored. Sampling then begins with channel 0.
- R2: Within a sweep, `scanCh` takes the values 0 to NUM_CH-1 in ascending order. Each channel holds for two cycles, and `scanSample` is high only in the first of the two.
- R3: A channel's count rises by exactly one for each sample cycle in which `eventFlag` is 1. Every other sample cycle leaves it unchanged. A 1 on `eventFlag` while `scanSample` is low has no effect.
- R4: With SATURATE=0, an event on a count of 4095 (all CNT_W bits set) makes it 0.
- R5: With SATURATE=1, an event on a count of 4095 leaves it at 4095.
- R6: `scanDone` is a one-cycle pulse in the cycle after the last channel's write-back. `hostWindow` is high for HOST_WIN cycles starting with that cycle, and the next sweep follows at once. One full period is 2*NUM_CH+HOST_WIN cycles.
- R7: A host read (`hostEn`=1, `hostWe`=0) presents the addressed channel's count on `hostRData` one cycle later. `hostRData` keeps that value until the next host read.
- R8: A host write (`hostEn`=1, `hostWe`=1) sets the addressed channel's count to `hostWData`. The count is stored in the low CNT_W bits of the RAM word and the upper bits are written as zero.
- R9: A host write to the channel that is in its read or write-back slot takes effect. That channel's scan result, including any pending event, is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eventFlag | input | 1 | Pending-event bit for channel `scanCh`, sampled while `scanSample` is high |
| scanCh | output | CH_W | Channel currently being updated |
| scanSample | output | 1 | High in the cycle where `eventFlag` is sampled |
| scanDone | output | 1 | One-cycle pulse at the end of a sweep |
| hostWindow | output | 1 | High during the host access slot |
| hostEn | input | 1 | Host access request |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostAddr | input | CH_W | Host channel address |
| hostWData | input | CNT_W | Count value for a host write |
| hostRData | output | CNT_W | Count returned by the last host read |

## Verification
The increment assertions assume that the word read in a channel's first slot cycle is the one that feeds its write-back. Host writes to that channel during the slot are therefore excluded in the property condition. The stimulus only makes such writes in two deliberate collision cases. All other host traffic is confined to `hostWindow`, so the host reads settled counts. `eventFlag` is held at 1 in every non-sample cycle (the arm cycle, write-back cycles and the host window), which exercises the assumption that only sample cycles count. The maximum-value cases are reached by preloading a count of 4094 through the host port rather than by sweeping thousands of times.

// File: rtl/tally_pkg.sv
package tally_pkg;

  // Strobes from the sequencer to the datapath for one channel slot.
  typedef struct packed {
    logic rd;   // read count, sample event flag
    logic wr;   // write count back
  } scanStrobe_t;

  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_SCAN = 2'd1,
    ST_WIN  = 2'd2
  } seqState_e;

endpackage

// File: rtl/tally_ram.sv
module tally_ram #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 16,
  parameter int KEEP_W = 12,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              enA,
  input  logic              weA,
  input  logic [AW-1:0]     addrA,
  input  logic [WORD_W-1:0] dA,
  output logic [KEEP_W-1:0] qA,
  input  logic              enB,
  input  logic              weB,
  input  logic [AW-1:0]     addrB,
  input  logic [WORD_W-1:0] dB,
  output logic [KEEP_W-1:0] qB
);

  logic [WORD_W-1:0] mem [DEPTH];

  // Port B is written last, so a same-address host write overrides.
  always_ff @(posedge clk) begin
    if (weA) mem[addrA] <= dA;
    if (enB && weB) mem[addrB] <= dB;
  end

  always_ff @(posedge clk) begin
    if (enA) qA <= mem[addrA][KEEP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (enB && !weB) qB <= mem[addrB][KEEP_W-1:0];
  end

endmodule

// File: rtl/tally_ctrl.sv
module tally_ctrl
  import tally_pkg::*;
#(
  parameter int NUM_CH   = 64,
  parameter int CH_W     = 6,
  parameter int HOST_WIN = 96
) (
  input  logic            clk,
  input  logic            rst,
  output scanStrobe_t     strobe,
  output logic [CH_W-1:0] scanCh,
  output logic            scanDone,
  output logic            hostWindow
);

  localparam int WIN_W = $clog2(HOST_WIN + 1);
  localparam logic [CH_W-1:0]  LAST_CH   = CH_W'(NUM_CH - 1);
  localparam logic [WIN_W-1:0] LAST_SLOT = WIN_W'(HOST_WIN - 1);

  seqState_e        state;
  logic             writeHalf;
  logic [WIN_W-1:0] winCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ARM;
      scanCh    <= '0;
      writeHalf <= 1'b0;
      winCnt    <= '0;
    end else begin
      unique case (state)
        ST_ARM: begin
          state     <= ST_SCAN;
          scanCh    <= '0;
          writeHalf <= 1'b0;
        end
        ST_SCAN: begin
          if (!writeHalf) begin
            writeHalf <= 1'b1;
          end else begin
            writeHalf <= 1'b0;
            if (scanCh == LAST_CH) begin
              state  <= ST_WIN;
              winCnt <= '0;
            end else begin
              scanCh <= scanCh + 1'b1;
            end
          end
        end
        ST_WIN: begin
          if (winCnt == LAST_SLOT) begin
            state  <= ST_SCAN;
            scanCh <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        default: state <= ST_ARM;
      endcase
    end
  end

  always_comb begin
    strobe.rd  = (state == ST_SCAN) && !writeHalf;
    strobe.wr  = (state == ST_SCAN) && writeHalf;
    hostWindow = (state == ST_WIN);
    scanDone   = (state == ST_WIN) && (winCnt == '0);
  end

  AST_ARM_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!strobe.rd && !strobe.wr && !hostWindow && scanCh == '0)); // R1

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    strobe.rd |=> (strobe.wr && $stable(scanCh))); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    scanDone |=> !scanDone); // R6

  AST_DONE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    scanDone |-> (hostWindow && !strobe.rd && !strobe.wr)); // R6

endmodule

// File: rtl/tally_dpath.sv
module tally_dpath
  import tally_pkg::*;
#(
  parameter int CH_W      = 6,
  parameter int CNT_W     = 12,
  parameter int RAM_DEPTH = 256,
  parameter int RAM_W     = 16,
  parameter bit SATURATE  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  scanStrobe_t      strobe,
  input  logic [CH_W-1:0]  scanCh,
  input  logic             eventFlag,
  input  logic             hostEn,
  input  logic             hostWe,
  input  logic [CH_W-1:0]  hostAddr,
  input  logic [CNT_W-1:0] hostWData,
  output logic [CNT_W-1:0] hostRData
);

  localparam int AW = $clog2(RAM_DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             flagQ;
  logic             killQ;
  logic             hostHit;
  logic             scanWe;
  logic [CNT_W-1:0] rdCount;
  logic [CNT_W-1:0] nextCount;
  logic [AW-1:0]    scanAddr;
  logic [AW-1:0]    hostRamAddr;
  logic [RAM_W-1:0] scanWord;
  logic [RAM_W-1:0] hostWord;

  // Host write aimed at the channel whose slot is in progress.
  assign hostHit = hostEn && hostWe && (hostAddr == scanCh);

  always_ff @(posedge clk) begin
    if (strobe.rd) begin
      flagQ <= eventFlag;
      killQ <= hostHit;
    end
  end

  assign scanWe = strobe.wr && !killQ && !hostHit;

  generate
    if (SATURATE) begin : g_sat
      assign nextCount = (flagQ && rdCount != CNT_MAX) ? rdCount + 1'b1 : rdCount;
      AST_SAT_CAP: assert property (@(posedge clk) disable iff (rst)
        (strobe.wr && rdCount == CNT_MAX) |-> (nextCount == CNT_MAX)); // R5
    end else begin : g_wrap
      assign nextCount = flagQ ? rdCount + 1'b1 : rdCount;
    end
  endgenerate

  always_comb begin
    scanAddr = '0;
    scanAddr[CH_W-1:0] = scanCh;
    hostRamAddr = '0;
    hostRamAddr[CH_W-1:0] = hostAddr;
    scanWord = '0;
    scanWord[CNT_W-1:0] = nextCount;
    hostWord = '0;
    hostWord[CNT_W-1:0] = hostWData;
  end

  tally_ram #(
    .DEPTH (RAM_DEPTH),
    .WORD_W(RAM_W),
    .KEEP_W(CNT_W),
    .AW    (AW)
  ) u_ram (
    .clk  (clk),
    .enA  (strobe.rd),
    .weA  (scanWe),
    .addrA(scanAddr),
    .dA   (scanWord),
    .qA   (rdCount),
    .enB  (hostEn),
    .weB  (hostWe),
    .addrB(hostRamAddr),
    .dB   (hostWord),
    .qB   (hostRData)
  );

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    strobe.wr |-> (nextCount == rdCount || nextCount == rdCount + 1'b1)); // R3

  AST_NO_FLAG_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobe.wr && !flagQ) |-> (nextCount == rdCount)); // R3

  AST_HOST_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (strobe.rd && hostHit) |=> !scanWe); // R9

endmodule

// File: rtl/event_tally.sv
module event_tally
  import tally_pkg::*;
#(
  parameter int NUM_CH    = 64,
  parameter int CNT_W     = 12,
  parameter int RAM_DEPTH = 256,
  parameter int RAM_W     = 16,
  parameter int HOST_WIN  = 96,
  parameter bit SATURATE  = 1'b0,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eventFlag,
  output logic [CH_W-1:0]  scanCh,
  output logic             scanSample,
  output logic             scanDone,
  output logic             hostWindow,
  input  logic             hostEn,
  input  logic             hostWe,
  input  logic [CH_W-1:0]  hostAddr,
  input  logic [CNT_W-1:0] hostWData,
  output logic [CNT_W-1:0] hostRData
);

  scanStrobe_t strobe;

  tally_ctrl #(
    .NUM_CH  (NUM_CH),
    .CH_W    (CH_W),
    .HOST_WIN(HOST_WIN)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .scanCh    (scanCh),
    .scanDone  (scanDone),
    .hostWindow(hostWindow)
  );

  tally_dpath #(
    .CH_W     (CH_W),
    .CNT_W    (CNT_W),
    .RAM_DEPTH(RAM_DEPTH),
    .RAM_W    (RAM_W),
    .SATURATE (SATURATE)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .scanCh   (scanCh),
    .eventFlag(eventFlag),
    .hostEn   (hostEn),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .hostWData(hostWData),
    .hostRData(hostRData)
  );

  assign scanSample = strobe.rd;

endmodule

// File: tb/event_tally_test.sv
module event_tally_test;

  localparam int NCH  = 64;
  localparam int CW   = 12;
  localparam int WIN  = 96;
  localparam int CMAX = 4095;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          eventFlag;
  logic [5:0]    scanCh;
  logic          scanSample, scanDone, hostWindow;
  logic          hostEn, hostWe;
  logic [5:0]    hostAddr;
  logic [CW-1:0] hostWData;
  logic [CW-1:0] hostRData;

  logic [5:0]    satCh;
  logic          satSample, satDone, satWindow;
  logic [CW-1:0] satRData;

  event_tally #(.NUM_CH(NCH), .CNT_W(CW), .HOST_WIN(WIN), .SATURATE(1'b0)) uut (
    .clk(clk), .rst(rst), .eventFlag(eventFlag), .scanCh(scanCh),
    .scanSample(scanSample), .scanDone(scanDone), .hostWindow(hostWindow),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWData(hostWData), .hostRData(hostRData));

  event_tally #(.NUM_CH(NCH), .CNT_W(CW), .HOST_WIN(WIN), .SATURATE(1'b1)) uutSat (
    .clk(clk), .rst(rst), .eventFlag(eventFlag), .scanCh(satCh),
    .scanSample(satSample), .scanDone(satDone), .hostWindow(satWindow),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWData(hostWData), .hostRData(satRData));

  int errs = 0;
  int checks = 0;
  int modelW [NCH];
  int modelS [NCH];
  int sweep = 0;
  int cyc = 0;
  int lastDone = -1;
  int winLen = 0;
  int expCh = 0;
  int forceCh = -1;
  bit evOn = 1'b0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pat(input int c, input int s);
    return (((c * 5 + s * 3 + c / 7) % 4) == 1) || (c == forceCh);
  endfunction

  // One cycle: advance to the falling edge, track timing, drive the flag.
  task automatic tick();
    bit f;
    @(negedge clk);
    cyc++;
    if (scanDone) begin
      if (lastDone >= 0) check("R6 sweep period", cyc - lastDone, 2 * NCH + WIN);
      check("R6 window open at done", int'(hostWindow), 1);
      check("R6 saturating copy in step", int'(satDone), 1);
      lastDone = cyc;
      sweep++;
    end
    if (hostWindow) winLen++;
    else if (winLen != 0) begin
      check("R6 window length", winLen, WIN);
      winLen = 0;
    end
    if (scanSample) begin
      check("R2 scan order", int'(scanCh), expCh);
      expCh = (expCh + 1) % NCH;
      f = evOn && pat(int'(scanCh), sweep);
      if (f) begin
        modelW[scanCh] = (modelW[scanCh] + 1) % (CMAX + 1);
        if (modelS[scanCh] != CMAX) modelS[scanCh] = modelS[scanCh] + 1;
      end
      eventFlag = f;
    end else begin
      eventFlag = 1'b1;  // must be ignored outside sample cycles (R3)
    end
  endtask

  task automatic waitDone();
    do tick(); while (!scanDone);
  endtask

  task automatic hostWrite(input int c, input int v);
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = 6'(c); hostWData = CW'(v);
    tick();
    hostEn = 1'b0; hostWe = 1'b0;
    modelW[c] = v;
    modelS[c] = v;
  endtask

  task automatic hostRead(input int c, output int w, output int s);
    hostEn = 1'b1; hostWe = 1'b0; hostAddr = 6'(c);
    tick();
    hostEn = 1'b0;
    w = int'(hostRData);
    s = int'(satRData);
  endtask

  task automatic readAll();
    int w, s;
    for (int c = 0; c < NCH; c++) begin
      hostRead(c, w, s);
      check("R3 R7 count readback (wrap)", w, modelW[c]);
      check("R3 R7 count readback (saturate)", s, modelS[c]);
    end
  endtask

  initial begin
    int w, s;
    rst = 1'b1; eventFlag = 1'b1; hostEn = 1'b0; hostWe = 1'b0;
    hostAddr = '0; hostWData = '0;
    for (int c = 0; c < NCH; c++) begin modelW[c] = 0; modelS[c] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset scanSample", int'(scanSample), 0);
    check("R1 reset scanDone", int'(scanDone), 0);
    check("R1 reset hostWindow", int'(hostWindow), 0);
    check("R1 reset scanCh", int'(scanCh), 0);
    rst = 1'b0;
    check("R1 arm cycle no sampling", int'(scanSample), 0);
    tick();
    check("R1 first sample cycle", int'(scanSample), 1);
    check("R1 first sample channel", int'(scanCh), 0);

    // First window: clear every channel through the host port (R8).
    waitDone();
    for (int c = 0; c < NCH; c++) hostWrite(c, 0);
    evOn = 1'b1;

    waitDone();
    readAll();
    repeat (3) tick();
    check("R7 read data held", int'(hostRData), modelW[NCH-1]);

    waitDone();
    readAll();
    hostWrite(5, CMAX - 1);
    hostWrite(9, 1234);
    hostRead(9, w, s);
    check("R8 preload readback (wrap)", w, 1234);
    check("R8 preload readback (saturate)", s, 1234);
    forceCh = 5;

    waitDone();
    hostRead(5, w, s);
    check("R4 reaches maximum", w, CMAX);
    check("R5 reaches maximum", s, CMAX);

    waitDone();
    hostRead(5, w, s);
    check("R4 wraps to zero", w, 0);
    check("R5 holds at maximum", s, CMAX);
    readAll();

    // Collision in the read slot of channel 20 (R9).
    do tick(); while (!(scanSample && scanCh == 6'd20));
    eventFlag = 1'b1;
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = 6'd20; hostWData = 12'd777;
    modelW[20] = 777; modelS[20] = 777;
    tick();
    hostEn = 1'b0; hostWe = 1'b0;

    // Collision in the write-back slot of channel 30 (R9).
    do tick(); while (!(scanSample && scanCh == 6'd30));
    eventFlag = 1'b1;
    tick();
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = 6'd30; hostWData = 12'd555;
    modelW[30] = 555; modelS[30] = 555;
    tick();
    hostEn = 1'b0; hostWe = 1'b0;

    waitDone();
    hostRead(20, w, s);
    check("R9 host wins in read slot", w, 777);
    check("R9 host wins in read slot (saturate)", s, 777);
    hostRead(30, w, s);
    check("R9 host wins in write slot", w, 555);
    check("R9 host wins in write slot (saturate)", s, 555);
    readAll();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule